// File: doc/BRIEF.md
# Two-Digit BCD Countdown Timer

This block is a two-digit decimal countdown timer driven by three push buttons: one that starts and stops the count, and one set button for each digit. A five-state controller moves between idle, setting the tens digit, setting the ones digit, running and stopped. In a set state, each press of that digit's set button advances the digit by one. After 9 the digit wraps to 0.

While running, the pair counts down by one on every cycle where the tick enable input is high. When the ones digit goes from 0 to 9 it borrows from the tens digit. When the count reaches 00 the controller leaves the run state and raises the alarm. The alarm stays high until any button is pressed. That press clears the alarm and returns the controller to idle.

The buttons are raw inputs. Each one passes through a synchroniser and a rising-edge detector, so a held button counts as one press. Both digit values are brought out for a display stage that lies outside this block.

Top module: `bcd_countdown_timer`

## Requirements
- R1: A synchronous active-high reset clears both digits to 0, clears the alarm and puts the controller in idle. In idle, tick enable changes nothing.
- R2: Pressing the tens set button in idle or stopped enters tens-set without changing the digit. Each further tens press adds one to the tens digit, and 9 wraps to 0.
- R3: Pressing the ones set button in idle, stopped or tens-set enters ones-set without changing the digit. Each further ones press adds one to the ones digit, and 9 wraps to 0.
- R4: In run, each cycle with tick enable high decrements the ones digit. The tens digit decrements on the same tick only when the ones digit was 0, and the ones digit then wraps to 9.
- R5: Start/stop pressed in run enters stopped. Start/stop pressed in idle, stopped or a set state enters run. Ticks outside run leave both digits unchanged.
- R6: When both digits are 0 in run, the next clock edge raises the alarm and leaves run. This also applies when run is entered with 00. The count never wraps below 00.
- R7: The alarm stays high until any button is pressed. That press clears the alarm and returns the controller to idle with the digits unchanged. The next set press only enters a set state.
- R8: A button held for any number of cycles produces exactly one action.
- R9: Set button presses in run have no effect on the digits or on the count.
- R10: Each digit always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-down enable pulse, acted on only in run |
| btn_start_stop | input | 1 | Raw start/stop button |
| btn_set_tens | input | 1 | Raw tens-digit set button |
| btn_set_ones | input | 1 | Raw ones-digit set button |
| tens_bcd | output | 4 | Tens digit, BCD |
| ones_bcd | output | 4 | Ones digit, BCD |
| alarm | output | 1 | High from expiry until the next button press |

## Verification
The hardest situation to reach from the ports is the cleanup after expiry. The bench must show that the press which clears the alarm does nothing else. To do this, it first counts a loaded value down through a borrow to 00. It then applies extra ticks to show the count holds at 00 under the alarm. Next it clears the alarm with a set press. It then shows that the following set press only enters the set state, and that only the press after that changes the digit. This proves the controller really passed through idle. A second case starts a count at 00 to reach the immediate-expiry path.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;

    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_TOP  = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SET_TENS = 3'd1,
        ST_SET_ONES = 3'd2,
        ST_RUN      = 3'd3,
        ST_STOP     = 3'd4
    } tmr_state_e;

    typedef struct packed {
        logic start_stop;
        logic set_tens;
        logic set_ones;
    } btn_evt_t;

    localparam int NUM_BTN = $bits(btn_evt_t);

    typedef struct packed {
        logic up;
        logic dn;
    } dig_cmd_t;

    function automatic bcd_t bcd_inc(input bcd_t v);
        return (v >= BCD_TOP) ? BCD_ZERO : bcd_t'(v + 1'b1);
    endfunction

    function automatic bcd_t bcd_dec(input bcd_t v);
        return (v == BCD_ZERO || v > BCD_TOP) ? BCD_TOP : bcd_t'(v - 1'b1);
    endfunction

endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
    parameter int NUM         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] raw,
    output logic [NUM-1:0] pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    for (genvar i = 0; i < NUM; i++) begin : g_btn
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[SYNC_STAGES-2:0], raw[i]};
                prev <= sh[TOP];
            end
        end

        assign pulse[i] = sh[TOP] & ~prev;

        AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
            pulse[i] |=> !pulse[i]) else $error("press pulse lasted two cycles"); // R8
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dig_cmd_t cmd,
    output bcd_t     value,
    output logic     at_zero,
    output logic     at_nine
);
    bcd_t cur, nxt;

    always_comb begin
        unique case ({cmd.up, cmd.dn})
            2'b10:   nxt = bcd_inc(cur);
            2'b01:   nxt = bcd_dec(cur);
            default: nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= BCD_ZERO;
        else     cur <= nxt;
    end

    assign value   = cur;
    assign at_zero = (cur == BCD_ZERO);
    assign at_nine = (cur == BCD_TOP);

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        value <= BCD_TOP) else $error("digit out of BCD range"); // R10
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cmd.up && !cmd.dn && at_nine) |=> at_zero) else $error("up wrap wrong"); // R2
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cmd.dn && !cmd.up && at_zero) |=> at_nine) else $error("down wrap wrong"); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.up == cmd.dn) |=> $stable(value)) else $error("digit moved without command"); // R5
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
    import bcd_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btn_evt_t   evt,
    input  logic       tick_en,
    input  logic       tens_zero,
    input  logic       ones_zero,
    output dig_cmd_t   tens_cmd,
    output dig_cmd_t   ones_cmd,
    output logic       alarm,
    output tmr_state_e state
);
    tmr_state_e nxt_state;
    logic       nxt_alarm;
    logic       any_press;
    logic       expired;

    assign any_press = evt.start_stop | evt.set_tens | evt.set_ones;
    assign expired   = tens_zero & ones_zero;

    always_comb begin
        nxt_state = state;
        nxt_alarm = alarm;
        tens_cmd  = '0;
        ones_cmd  = '0;
        if (alarm) begin
            if (any_press) begin
                nxt_state = ST_IDLE;
                nxt_alarm = 1'b0;
            end
        end else begin
            unique case (state)
                ST_IDLE, ST_STOP: begin
                    if (evt.start_stop)    nxt_state = ST_RUN;
                    else if (evt.set_tens) nxt_state = ST_SET_TENS;
                    else if (evt.set_ones) nxt_state = ST_SET_ONES;
                end
                ST_SET_TENS: begin
                    if (evt.start_stop)    nxt_state = ST_RUN;
                    else if (evt.set_tens) tens_cmd.up = 1'b1;
                    else if (evt.set_ones) nxt_state = ST_SET_ONES;
                end
                ST_SET_ONES: begin
                    if (evt.start_stop)    nxt_state = ST_RUN;
                    else if (evt.set_ones) ones_cmd.up = 1'b1;
                    else if (evt.set_tens) nxt_state = ST_SET_TENS;
                end
                ST_RUN: begin
                    if (expired) begin
                        nxt_state = ST_STOP;
                        nxt_alarm = 1'b1;
                    end else if (evt.start_stop) begin
                        nxt_state = ST_STOP;
                    end else if (tick_en) begin
                        ones_cmd.dn = 1'b1;
                        tens_cmd.dn = ones_zero;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            alarm <= 1'b0;
        end else begin
            state <= nxt_state;
            alarm <= nxt_alarm;
        end
    end

    AST_ALARM_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> ($past(state) == ST_RUN && state == ST_STOP)) else $error("alarm not from run"); // R6
    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (alarm && !any_press) |=> alarm) else $error("alarm dropped without press"); // R7
    AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (alarm && any_press) |=> (!alarm && state == ST_IDLE)) else $error("alarm clear wrong"); // R7
    AST_RUN_EXPIRES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && tens_zero && ones_zero) |=> alarm) else $error("no alarm at 00"); // R6
endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer
    import bcd_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       btn_start_stop,
    input  logic       btn_set_tens,
    input  logic       btn_set_ones,
    output logic [3:0] tens_bcd,
    output logic [3:0] ones_bcd,
    output logic       alarm
);
    logic [NUM_BTN-1:0] raw_btn;
    logic [NUM_BTN-1:0] btn_pulse;
    btn_evt_t           evt;
    dig_cmd_t           tens_cmd, ones_cmd;
    logic               tens_zero, ones_zero;
    logic               tens_nine, ones_nine;
    bcd_t               tens_val, ones_val;
    tmr_state_e         state;

    assign raw_btn = {btn_start_stop, btn_set_tens, btn_set_ones};
    assign evt     = btn_evt_t'(btn_pulse);

    btn_edge #(.NUM(NUM_BTN), .SYNC_STAGES(SYNC_STAGES)) u_btn (
        .clk(clk), .rst(rst), .raw(raw_btn), .pulse(btn_pulse)
    );

    bcd_digit u_tens (
        .clk(clk), .rst(rst), .cmd(tens_cmd),
        .value(tens_val), .at_zero(tens_zero), .at_nine(tens_nine)
    );

    bcd_digit u_ones (
        .clk(clk), .rst(rst), .cmd(ones_cmd),
        .value(ones_val), .at_zero(ones_zero), .at_nine(ones_nine)
    );

    timer_ctrl u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .tick_en(tick_en),
        .tens_zero(tens_zero), .ones_zero(ones_zero),
        .tens_cmd(tens_cmd), .ones_cmd(ones_cmd),
        .alarm(alarm), .state(state)
    );

    assign tens_bcd = tens_val;
    assign ones_bcd = ones_val;

    AST_BORROW_SRC: assert property (@(posedge clk) disable iff (rst)
        tens_cmd.dn |-> (ones_cmd.dn && ones_zero)) else $error("borrow without ones at 0"); // R4
    AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ones_cmd.dn && ones_zero) |=> ones_nine) else $error("ones did not wrap to 9"); // R4
    AST_NO_SET_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (!tens_cmd.up && !ones_cmd.up)) else $error("set in run"); // R9
    AST_NO_TICK_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> (!tens_cmd.dn && !ones_cmd.dn)) else $error("count outside run"); // R5
endmodule

// File: tb/bcd_countdown_timer_tb.sv
module bcd_countdown_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       b_ss = 1'b0, b_t = 1'b0, b_o = 1'b0;
    logic [3:0] tens_bcd, ones_bcd;
    logic       alarm;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cycles = 0;

    always #5 clk = ~clk;

    bcd_countdown_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .btn_start_stop(b_ss), .btn_set_tens(b_t), .btn_set_ones(b_o),
        .tens_bcd(tens_bcd), .ones_bcd(ones_bcd), .alarm(alarm)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_val(input string tag, input int t, input int o, input int al);
        chk({tag, " count"}, tens_bcd * 10 + ones_bcd, t * 10 + o);
        chk({tag, " alarm"}, int'(alarm), al);
    endtask

    // which: 0 start/stop, 1 tens set, 2 ones set
    task automatic press(input int which, input int hold = 4);
        @(negedge clk);
        case (which)
            0: b_ss = 1'b1;
            1: b_t  = 1'b1;
            default: b_o = 1'b1;
        endcase
        repeat (hold) @(negedge clk);
        b_ss = 1'b0; b_t = 1'b0; b_o = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic presses(input int which, input int n);
        for (int i = 0; i < n; i++) press(which);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk_val("R1 after reset", 0, 0, 0);
        tick(3);
        chk_val("R1 idle ignores tick", 0, 0, 0);
    endtask

    task automatic t_set;
        press(1);
        chk_val("R2 entry press no change", 0, 0, 0);
        presses(1, 3);
        chk_val("R2 tens advance", 3, 0, 0);
        press(2);
        chk_val("R3 entry press no change", 3, 0, 0);
        presses(2, 5);
        chk_val("R3 ones advance", 3, 5, 0);
        press(1);
        presses(1, 7);
        chk_val("R2 tens wrap 9->0", 0, 5, 0);
        press(1);
        chk_val("R2 tens after wrap", 1, 5, 0);
        press(2);
        presses(2, 5);
        chk_val("R3 ones wrap 9->0", 1, 0, 0);
        presses(2, 2);
        chk_val("R3 ones after wrap", 1, 2, 0);
    endtask

    task automatic t_run;
        press(0);
        tick(2);
        chk_val("R4 ones decrement", 1, 0, 0);
        tick(1);
        chk_val("R4 borrow 10->09", 0, 9, 0);
        tick(3);
        chk_val("R4 decrement", 0, 6, 0);
    endtask

    task automatic t_stop;
        press(0);
        tick(3);
        chk_val("R5 stopped ignores tick", 0, 6, 0);
        press(0);
        tick(1);
        chk_val("R5 resume from stop", 0, 5, 0);
        press(1);
        press(2);
        chk_val("R9 set ignored in run", 0, 5, 0);
        tick(1);
        chk_val("R9 still running", 0, 4, 0);
        press(0, 20);
        tick(2);
        chk_val("R8 long hold stops once", 0, 4, 0);
        press(0);
    endtask

    task automatic t_expire;
        tick(3);
        chk_val("R6 at 01 no alarm", 0, 1, 0);
        tick(1);
        chk_val("R6 alarm at 00", 0, 0, 1);
        tick(3);
        chk_val("R6 no wrap below 00", 0, 0, 1);
        repeat (10) @(negedge clk);
        chk_val("R7 alarm held", 0, 0, 1);
        press(2);
        chk_val("R7 press clears alarm", 0, 0, 0);
        tick(2);
        chk_val("R7 idle after clear", 0, 0, 0);
        press(2);
        chk_val("R7 next press only enters set", 0, 0, 0);
        press(2);
        chk_val("R7 then set advances", 0, 1, 0);
    endtask

    task automatic t_zero_start;
        presses(2, 9);
        chk_val("R3 back to 00", 0, 0, 0);
        press(0);
        chk_val("R6 start at 00 alarms", 0, 0, 1);
        press(0);
        chk_val("R7 start clears alarm", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set();
        t_run();
        t_stop();
        t_expire();
        t_zero_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule